// File: doc/BRIEF.md
# Code-Density Calibration Table Builder

This block builds a calibration lookup table for the fine codes of a tapped-delay-line time digitiser. Its input is a stream of hit samples that are not correlated with the sampling clock. Each sample carries a fine code and a phase bit. The phase bit says which of two consecutive fast sampling periods the hit fell in. The table maps each merged fine index to a time in picoseconds. That time is the position of the index inside a two-period window.

A build starts with the `start` pulse and runs in three passes over the incoming stream. The first pass reads a programmed number of samples, Ω, and records the largest fine code N. The chain therefore has N+1 usable taps per period.

The second pass reads Ω more samples. It folds the codes of both periods into one chain of merged indices 0..2N, where the last tap of the first period and the first tap of the second period share index N. It counts hits per merged index in a histogram.

The block then integrates that histogram with the trapezoid rule and writes one picosecond value per merged index. After `done` rises, the lookup port returns the value of any index.

Top module: `tdc_cal_builder`

## Requirements
- R1: After reset, `busy`, `done` and `accepting` are 0 and `tap_max` is 0. A `start` sampled high at a rising clock edge aborts any build in progress. From the next cycle on, `busy` is 1 and `done` is 0.
- R2: After `start`, the block clears its histogram for 2^(CODE_W+1) cycles with `accepting` low. The first Ω samples accepted after that set `tap_max` to the largest `in_code` among them, whatever their phase.
- R3: The next Ω accepted samples are histogrammed by merged index. Let c' be `in_code` clamped to at most N. With `in_phase` 0 the merged index is c'; with `in_phase` 1 it is N+c'.
- R4: Each histogram count saturates at 2^CNT_W−1.
- R5: The table value of merged index 0 is 0.
- R6: For 1 ≤ k ≤ 2N, the table value is floor((T_PS·S(k) + floor(Ω/2)) / Ω), saturated at 2^TIME_W−1. Here S(k) = Σ_{i=1..k} (n(i−1)+n(i)) and n is the histogram count.
- R7: `cfg_samples` is captured at `start`. A value of 0 is treated as Ω = 1.
- R8: When the table is complete, `done` is 1 and both `busy` and `accepting` are 0. These levels hold until the next `start`.
- R9: `lk_time` shows the table value for `lk_idx` one clock edge after `lk_idx` is presented. An index above 2N returns the value of index 2N.
- R10: A sample is ignored, with no effect on `tap_max` or on any table value, if `in_valid` is low or `accepting` is low in the cycle it is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin (or restart) a table build |
| cfg_samples | input | SMP_W | Sample count Ω per pass |
| in_valid | input | 1 | Hit sample present |
| in_phase | input | 1 | Sampling-period tag of the hit (0 first, 1 second) |
| in_code | input | CODE_W | Fine code of the hit |
| accepting | output | 1 | Samples presented this cycle are taken |
| busy | output | 1 | Build in progress |
| done | output | 1 | Table complete |
| tap_max | output | CODE_W | Largest fine code N found in the first pass |
| lk_idx | input | CODE_W+1 | Merged index to look up |
| lk_time | output | TIME_W | Calibrated time of the looked-up index, picoseconds |

## Verification
`busy` and `done` change at the first edge after `start`. The bench drives `start` on a falling edge and reads both flags at the next falling edge.

`accepting` is a register, so the bench reads it at the falling edge, where it already has the value that the following rising edge acts on. The bench uses it to decide whether a driven sample counts. While `accepting` is low it drives junk hits with code 127.

`done` rises some cycles after the last accepted sample: one drain cycle, then a read cycle and a divide of DIV_W cycles for each merged index. The bench therefore polls `done` rather than predicting the cycle.

Each lookup is driven at a falling edge and compared at the next falling edge, which checks the single-edge read latency.

// File: rtl/tdc_cal_pkg.sv
package tdc_cal_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_MAXSCAN,
    ST_HIST,
    ST_DRAIN,
    ST_FETCH,
    ST_STEP,
    ST_DIVIDE,
    ST_DONE
  } cal_state_e;

endpackage

// File: rtl/tdc_cal_hist.sv
module tdc_cal_hist #(
  parameter int IDX_W = 8,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_addr,
  input  logic             smp_valid,
  input  logic [IDX_W-1:0] smp_idx,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [CNT_W-1:0] rd_data
);

  localparam int DEPTH = 1 << IDX_W;

  logic [CNT_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0] rd_q;
  logic             a_valid_q;
  logic [IDX_W-1:0] a_idx_q;
  logic             lw_valid_q;
  logic [IDX_W-1:0] lw_idx_q;
  logic [CNT_W-1:0] lw_data_q;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] bumped;

  // The memory read happens before the write in the same cycle, so the last
  // written value is forwarded when the next sample hits the same bin.
  assign base   = (lw_valid_q && (lw_idx_q == a_idx_q)) ? lw_data_q : rd_q;
  assign bumped = (base == '1) ? base : base + CNT_W'(1);
  assign rd_data = rd_q;

  always_ff @(posedge clk) begin
    rd_q <= mem_q[smp_valid ? smp_idx : rd_addr];
    if (clr_en)
      mem_q[clr_addr] <= '0;
    else if (a_valid_q)
      mem_q[a_idx_q] <= bumped;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_valid_q  <= 1'b0;
      a_idx_q    <= '0;
      lw_valid_q <= 1'b0;
      lw_idx_q   <= '0;
      lw_data_q  <= '0;
    end else begin
      a_valid_q  <= smp_valid;
      a_idx_q    <= smp_idx;
      lw_valid_q <= a_valid_q && !clr_en;
      lw_idx_q   <= a_idx_q;
      lw_data_q  <= bumped;
    end
  end

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (a_valid_q && !clr_en) |=> (lw_data_q != '0)) else $error("count wrapped to zero"); // R4

endmodule

// File: rtl/tdc_cal_divider.sv
module tdc_cal_divider #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic             done,
  output logic [NUM_W-1:0] quot
);

  localparam int STEP_W = $clog2(NUM_W);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_W - 1);

  logic [NUM_W-1:0]  quo_q;
  logic [DEN_W-1:0]  rem_q;
  logic [DEN_W-1:0]  den_q;
  logic [STEP_W-1:0] step_q;
  logic              run_q;
  logic              done_q;
  logic [DEN_W:0]    trial;
  logic [DEN_W:0]    diff;
  logic              fits;

  assign trial = {rem_q, quo_q[NUM_W-1]};
  assign fits  = trial >= {1'b0, den_q};
  assign diff  = trial - {1'b0, den_q};
  assign done  = done_q;
  assign quot  = quo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      step_q <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        quo_q  <= numer;
        rem_q  <= '0;
        den_q  <= denom;
        step_q <= '0;
        run_q  <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        quo_q <= {quo_q[NUM_W-2:0], fits};
        if (step_q == LAST_STEP) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q + STEP_W'(1);
        end
      end
    end
  end

  AST_REM_BELOW: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (rem_q < den_q)) else $error("remainder not below divisor"); // R6

endmodule

// File: rtl/tdc_cal_table.sv
module tdc_cal_table #(
  parameter int IDX_W  = 8,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [TIME_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [TIME_W-1:0] rdata
);

  localparam int DEPTH = 1 << IDX_W;

  logic [TIME_W-1:0] mem_q [DEPTH];
  logic [TIME_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we)
      mem_q[waddr] <= wdata;
    rd_q <= mem_q[raddr];
  end

  assign rdata = rd_q;

endmodule

// File: rtl/tdc_cal_builder.sv
module tdc_cal_builder
  import tdc_cal_pkg::*;
#(
  parameter int          CODE_W = 7,
  parameter int          CNT_W  = 24,
  parameter int          SMP_W  = 24,
  parameter int          TIME_W = 16,
  parameter int unsigned T_PS   = 1000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [SMP_W-1:0]    cfg_samples,
  input  logic                in_valid,
  input  logic                in_phase,
  input  logic [CODE_W-1:0]   in_code,
  output logic                accepting,
  output logic                busy,
  output logic                done,
  output logic [CODE_W-1:0]   tap_max,
  input  logic [CODE_W:0]     lk_idx,
  output logic [TIME_W-1:0]   lk_time
);

  localparam int IDX_W = CODE_W + 1;
  localparam int ACC_W = CNT_W + CODE_W + 2;
  localparam int T_W   = $clog2(T_PS + 1);
  localparam int DIV_W = ACC_W + T_W + 1;

  cal_state_e        state_q, state_d;
  logic [IDX_W-1:0]  clr_q, k_q, two_n, smp_idx, lk_addr;
  logic [CODE_W-1:0] n_max_q, code_cl;
  logic [SMP_W-1:0]  omega_q, smp_q;
  logic              last_smp, k_last, smp_valid, clr_en;
  logic [CNT_W-1:0]  prev_n_q, hist_rd;
  logic [ACC_W-1:0]  s_acc_q, s_next;
  logic [DIV_W-1:0]  numer, quot;
  logic              div_start, div_done;
  logic              tbl_we;
  logic [TIME_W-1:0] tbl_wd, quot_sat, chk_last_q;
  logic              busy_q, done_q, acc_q;

  // Index folding: the second period starts on the last tap of the first.
  assign two_n     = {n_max_q, 1'b0};
  assign code_cl   = (in_code > n_max_q) ? n_max_q : in_code;
  assign smp_idx   = in_phase ? ({1'b0, n_max_q} + {1'b0, code_cl}) : {1'b0, code_cl};
  assign smp_valid = (state_q == ST_HIST) && in_valid;
  assign clr_en    = (state_q == ST_CLEAR);
  assign last_smp  = (smp_q == omega_q - SMP_W'(1));
  assign k_last    = (k_q == two_n);

  // Trapezoid step: the running sum gains the previous and current count.
  assign s_next    = (k_q == '0) ? '0 : s_acc_q + ACC_W'(prev_n_q) + ACC_W'(hist_rd);
  assign numer     = DIV_W'(s_next) * DIV_W'(T_PS) + DIV_W'(omega_q >> 1);
  assign div_start = (state_q == ST_STEP) && (k_q != '0);
  assign quot_sat  = (|quot[DIV_W-1:TIME_W]) ? '1 : quot[TIME_W-1:0];
  assign tbl_we    = ((state_q == ST_STEP) && (k_q == '0)) ||
                     ((state_q == ST_DIVIDE) && div_done);
  assign tbl_wd    = (state_q == ST_STEP) ? '0 : quot_sat;
  assign lk_addr   = (lk_idx > two_n) ? two_n : lk_idx;

  assign accepting = acc_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign tap_max   = n_max_q;

  always_comb begin
    state_d = state_q;
    if (start) begin
      state_d = ST_CLEAR;
    end else begin
      case (state_q)
        ST_CLEAR:   if (clr_q == '1) state_d = ST_MAXSCAN;
        ST_MAXSCAN: if (in_valid && last_smp) state_d = ST_HIST;
        ST_HIST:    if (in_valid && last_smp) state_d = ST_DRAIN;
        ST_DRAIN:   state_d = ST_FETCH;
        ST_FETCH:   state_d = ST_STEP;
        ST_STEP:    if (k_q == '0) state_d = k_last ? ST_DONE : ST_FETCH;
                    else           state_d = ST_DIVIDE;
        ST_DIVIDE:  if (div_done) state_d = k_last ? ST_DONE : ST_FETCH;
        default:    state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      acc_q      <= 1'b0;
      clr_q      <= '0;
      omega_q    <= SMP_W'(1);
      smp_q      <= '0;
      n_max_q    <= '0;
      k_q        <= '0;
      prev_n_q   <= '0;
      s_acc_q    <= '0;
      chk_last_q <= '0;
    end else begin
      state_q <= state_d;
      busy_q  <= !(state_d inside {ST_IDLE, ST_DONE});
      done_q  <= (state_d == ST_DONE);
      acc_q   <= (state_d inside {ST_MAXSCAN, ST_HIST});
      if (tbl_we)
        chk_last_q <= tbl_wd;
      if (start) begin
        omega_q <= (cfg_samples == '0) ? SMP_W'(1) : cfg_samples;
        clr_q   <= '0;
        smp_q   <= '0;
        n_max_q <= '0;
        k_q     <= '0;
      end else begin
        case (state_q)
          ST_CLEAR: clr_q <= clr_q + IDX_W'(1);
          ST_MAXSCAN: if (in_valid) begin
            if (in_code > n_max_q) n_max_q <= in_code;
            smp_q <= last_smp ? '0 : smp_q + SMP_W'(1);
          end
          ST_HIST: if (in_valid) begin
            smp_q <= last_smp ? '0 : smp_q + SMP_W'(1);
          end
          ST_STEP: begin
            prev_n_q <= hist_rd;
            s_acc_q  <= s_next;
            if ((k_q == '0) && !k_last) k_q <= k_q + IDX_W'(1);
          end
          ST_DIVIDE: if (div_done && !k_last) k_q <= k_q + IDX_W'(1);
          default: ;
        endcase
      end
    end
  end

  tdc_cal_hist #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_hist (
    .clk       (clk),
    .rst       (rst),
    .clr_en    (clr_en),
    .clr_addr  (clr_q),
    .smp_valid (smp_valid),
    .smp_idx   (smp_idx),
    .rd_addr   (k_q),
    .rd_data   (hist_rd)
  );

  tdc_cal_divider #(.NUM_W(DIV_W), .DEN_W(SMP_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (div_start),
    .numer (numer),
    .denom (omega_q),
    .done  (div_done),
    .quot  (quot)
  );

  tdc_cal_table #(.IDX_W(IDX_W), .TIME_W(TIME_W)) u_table (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (k_q),
    .wdata (tbl_wd),
    .raddr (lk_addr),
    .rdata (lk_time)
  );

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy_q && !done_q)) else $error("start did not raise busy"); // R1
  AST_IDX_LIMIT: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> (smp_idx <= two_n)) else $error("merged index beyond 2N"); // R3
  AST_T0_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tbl_we && (k_q == '0)) |-> (tbl_wd == '0)) else $error("index 0 not zero"); // R5
  AST_TABLE_MONO: assert property (@(posedge clk) disable iff (rst)
    (tbl_we && (k_q != '0)) |-> (tbl_wd >= chk_last_q)) else $error("table not monotone"); // R6
  AST_OMEGA_NZ: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |-> (omega_q != '0)) else $error("zero sample count"); // R7
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy_q && done_q)) else $error("busy and done together"); // R8
  AST_ACC_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    acc_q |-> busy_q) else $error("accepting outside a build"); // R10

endmodule

// File: tb/tdc_cal_builder_test.sv
`timescale 1ns/1ps
module tdc_cal_builder_test;

  localparam int CODE_W = 7;
  localparam int CNT_W  = 12;
  localparam int SMP_W  = 16;
  localparam int TIME_W = 16;
  localparam int T_PS   = 1000;
  localparam longint CNT_MAX  = (64'd1 << CNT_W) - 1;
  localparam longint TIME_MAX = (64'd1 << TIME_W) - 1;

  logic clk = 1'b0;
  logic rst, start, in_valid, in_phase;
  logic [SMP_W-1:0]  cfg_samples;
  logic [CODE_W-1:0] in_code, tap_max;
  logic accepting, busy, done;
  logic [CODE_W:0]   lk_idx;
  logic [TIME_W-1:0] lk_time;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tdc_cal_builder #(.CODE_W(CODE_W), .CNT_W(CNT_W), .SMP_W(SMP_W),
                    .TIME_W(TIME_W), .T_PS(T_PS)) uut (
    .clk(clk), .rst(rst), .start(start), .cfg_samples(cfg_samples),
    .in_valid(in_valid), .in_phase(in_phase), .in_code(in_code),
    .accepting(accepting), .busy(busy), .done(done), .tap_max(tap_max),
    .lk_idx(lk_idx), .lk_time(lk_time)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic lookup(input int idx, input longint exp, input string tag);
    lk_idx = (CODE_W+1)'(idx);
    @(negedge clk);
    chk(longint'(lk_time) == exp, tag, longint'(lk_time), exp);
  endtask

  // mode 0: uniform codes; 1: all zero; 2: hist codes above N (clamp);
  // 3: every hist sample on one bin (saturation)
  task automatic run_build(input int om, input int mode);
    int eff, acc_n, mx, nn, w, c, ph, idx;
    longint cnt [0:255];
    longint s, t, tlast;
    string tag;
    eff = (om == 0) ? 1 : om;
    for (int i = 0; i < 256; i++) cnt[i] = 0;
    @(negedge clk);
    start = 1; cfg_samples = SMP_W'(om);
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1 && done == 1'b0, "R1 busy/done after start", {busy, done}, 2);
    acc_n = 0; mx = 0; nn = 0;
    while (acc_n < 2 * eff) begin
      if (accepting) begin
        if ($urandom % 4 != 0) begin
          ph = int'($urandom % 2);
          if (acc_n < eff) begin
            case (mode)
              0: c = int'($urandom % 101);
              1: c = 0;
              2: c = int'($urandom % 41);
              default: c = int'($urandom % 64);
            endcase
            if (c > mx) mx = c;
          end else begin
            nn = mx;
            case (mode)
              0: c = int'($urandom % 101);
              1: c = 0;
              2: c = int'($urandom % 128);
              default: begin c = 5; ph = 0; end
            endcase
            idx = (c > nn) ? nn : c;
            if (ph == 1) idx = idx + nn;
            if (cnt[idx] < CNT_MAX) cnt[idx] = cnt[idx] + 1;
          end
          in_valid = 1; in_phase = ph[0]; in_code = CODE_W'(c);
          acc_n++;
        end else begin
          in_valid = 0; in_phase = 1; in_code = '1;   // R10 invalid junk
        end
      end else begin
        in_valid = 1; in_phase = 1; in_code = '1;     // R10 not accepting
      end
      @(negedge clk);
    end
    in_valid = 0;
    nn = mx;
    w = 0;
    while (!done && w < 60000) begin @(negedge clk); w++; end
    chk(done == 1'b1 && busy == 1'b0 && accepting == 1'b0, "R8 completion flags",
        {done, busy, accepting}, 4);
    chk(int'(tap_max) == mx, "R2/R10 tap_max", tap_max, mx);
    s = 0; tlast = 0;
    for (int k = 0; k <= 2 * nn; k++) begin
      if (k == 0) t = 0;
      else begin
        s = s + cnt[k-1] + cnt[k];
        t = (longint'(T_PS) * s + eff / 2) / eff;
        if (t > TIME_MAX) t = TIME_MAX;
      end
      if (k == 0)         tag = "R5 t(0)";
      else if (om == 0)   tag = "R7 omega zero";
      else if (mode == 3) tag = "R4 saturated bin";
      else if (mode == 2) tag = "R3 clamped merge";
      else                tag = "R6 t(k)";
      lookup(k, t, tag);
      tlast = t;
    end
    lookup(2 * nn + 1, tlast, "R9 above 2N");
    lookup(255, tlast, "R9 top index");
    chk(done == 1'b1, "R8 done holds", done, 1);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; start = 0; cfg_samples = '0; in_valid = 0; in_phase = 0;
    in_code = '0; lk_idx = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy == 0 && done == 0 && accepting == 0 && tap_max == 0,
        "R1 reset state", {busy, done, accepting}, 0);

    run_build(3000, 0);
    run_build(0, 1);

    // R1 restart: an aborted build with code 127 must leave no trace
    @(negedge clk);
    start = 1; cfg_samples = SMP_W'(100);
    @(negedge clk);
    start = 0;
    while (!accepting) @(negedge clk);
    repeat (30) begin
      in_valid = 1; in_phase = 0; in_code = '1;
      @(negedge clk);
    end
    in_valid = 0;
    run_build(500, 2);

    run_build(5000, 3);
    summary();
  end

endmodule